// File: doc/BRIEF.md
# Modulo and Bit-Reversed Address Generator

This block keeps one data-memory pointer for a DSP loop and works out its next value every cycle. The data space is 64 Kbytes, so the pointer is a 16-bit byte address. There are three ways to update it. In linear mode the pointer moves up or down by a step given in bytes. In modulo mode the pointer runs around a circular buffer whose first and last addresses are programmable. Hardware folds back any overshoot past either boundary, so the loop code has no boundary test. In bit-reversed mode a modifier is added with the carry running from the high bit toward the low bit, which walks a radix-2 FFT buffer in bit-reversed index order.

The block has two outputs, both registered. `addr` is the current pointer. `nxt` is a preview of the value `addr` will take on the next update if the configuration does not change. A load strobe writes a new base pointer. An update strobe advances the pointer. With neither strobe high, the pointer holds. Word accesses keep address bit 0 cleared.

Top module: `agu_modrev`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, both `addr` and `nxt` read 0.
- R2: When `load` is high, the next `addr` is `ptr_in`, with bit 0 forced to 0 when `word`=1. If `load` and `upd` are high together, `load` wins.
- R3: With `load` and `upd` both low, `addr` keeps its value.
- R4: With `amode`=2'b00 (linear), each update adds `step` when `dec`=0 and subtracts it when `dec`=1, modulo 2^16.
- R5: With `amode`=2'b01 (modulo) and `dec`=0, a pointer inside the buffer whose sum passes `buf_hi` becomes `buf_lo` plus the overshoot. Here the buffer length is `buf_hi - buf_lo + G`, with G=2 when `word`=1 and G=1 when `word`=0.
- R6: With `amode`=2'b01 and `dec`=1, a pointer inside the buffer whose difference falls below `buf_lo` becomes `buf_hi` minus the undershoot, using the same buffer length as R5.
- R7: In modulo mode, an update that crosses no boundary behaves linearly. This includes an update that starts from a pointer outside [`buf_lo`, `buf_hi`].
- R8: With `amode`=2'b10 (bit-reversed), each update adds `rev_mod` to the pointer with the carry propagating from bit 15 toward bit 0.
  - `step` and `dec` have no effect.
  - Bits above the highest set bit of `rev_mod` are unchanged.
- R9: With `amode`=2'b11, the block behaves exactly as in bit-reversed mode.
- R10: When `word`=1, every loaded or updated `addr` has bit 0 cleared, in all modes.
- R11: After any cycle out of reset, `nxt` equals the value that one more update would give `addr` with the current configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load `ptr_in` into the pointer |
| upd | input | 1 | Advance the pointer once |
| ptr_in | input | 16 | Base pointer value to load |
| step | input | 16 | Step size in bytes (unsigned) |
| dec | input | 1 | 1 = decrement, 0 = increment (linear and modulo modes) |
| word | input | 1 | 1 = word access (bit 0 cleared, granularity 2) |
| amode | input | 2 | bit 0 = modulo enable, bit 1 = bit-reversed enable |
| buf_lo | input | 16 | First address of the circular buffer |
| buf_hi | input | 16 | Last address of the circular buffer (inclusive) |
| rev_mod | input | 16 | Bit-reversed modifier (half the buffer size in bytes) |
| addr | output | 16 | Current pointer |
| nxt | output | 16 | Pointer value after one more update |

## Verification
The bench sweeps every step size from the smallest up to the full buffer length, in both directions, for a word buffer and for an odd-length byte buffer. A step equal to the length must land on the same address, and a step one short of it must wrap by exactly one unit. A design that wrapped by the raw span instead of the span plus the granularity would drift by one unit on each wrap. A design that wrapped only one way would leave the buffer on a decrement.

Further checks cover the following corners:
- A pointer below the buffer must ignore the wrap logic.
- Linear runs through the 64K boundary must roll over cleanly.
- Bit-reversed runs over several buffer sizes, with an ignored step and direction, show whether the carry travels the wrong way or leaks above the modifier.
- Mode 2'b11 shows whether the mode priority is inverted.
- A load and an update in the same cycle show whether the load priority is inverted.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_LIN  = 2'b00,
    AM_MOD  = 2'b01,
    AM_REV  = 2'b10,
    AM_BOTH = 2'b11
  } agu_mode_e;
endpackage

// File: rtl/agu_modwrap.sv
// Linear and circular-buffer update for one pointer.
module agu_modwrap #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] p,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          dec,
  input  logic          word,
  input  logic          wrap_en,
  output logic [AW-1:0] q
);
  localparam int W = AW + 1;

  logic [W-1:0] p1, s1, lo1, hi1, gran, len, sum, res;

  always_comb begin
    p1   = {1'b0, p};
    s1   = {1'b0, step};
    lo1  = {1'b0, lo};
    hi1  = {1'b0, hi};
    gran = word ? W'(2) : W'(1);
    len  = hi1 - lo1 + gran;
    sum  = p1 + s1;
    if (!dec) begin
      if (wrap_en && (p1 <= hi1) && (sum > hi1)) res = sum - len;
      else                                       res = sum;
    end else begin
      if (wrap_en && (p1 >= lo1) && (s1 > (p1 - lo1))) res = p1 + len - s1;
      else                                             res = p1 - s1;
    end
    q = res[AW-1:0];
  end
endmodule

// File: rtl/agu_revadd.sv
// Addition with the carry running from the top bit toward bit 0.
module agu_revadd #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] p,
  input  logic [AW-1:0] m,
  output logic [AW-1:0] q
);
  logic [AW-1:0] p_r, m_r, s_r;

  assign s_r = p_r + m_r;

  for (genvar i = 0; i < AW; i++) begin : g_rev
    assign p_r[i]        = p[AW-1-i];
    assign m_r[i]        = m[AW-1-i];
    assign q[AW-1-i]     = s_r[i];
  end
endmodule

// File: rtl/agu_nextcalc.sv
// Next pointer value: mode select with bit-reverse priority, word masking.
module agu_nextcalc
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] p,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] rmod,
  input  logic          dec,
  input  logic          word,
  input  logic [1:0]    amode,
  output logic [AW-1:0] q
);
  logic [AW-1:0] q_lin, q_rev, q_sel, mask;
  logic          wrap_en, rev_en;

  assign wrap_en = amode[0];
  assign rev_en  = amode[1];
  assign mask    = word ? ~AW'(1) : '1;

  agu_modwrap #(.AW(AW)) u_wrap (
    .p(p), .step(step), .lo(lo), .hi(hi),
    .dec(dec), .word(word), .wrap_en(wrap_en), .q(q_lin)
  );

  agu_revadd #(.AW(AW)) u_rev (
    .p(p), .m(rmod), .q(q_rev)
  );

  always_comb begin
    q_sel = rev_en ? q_rev : q_lin;
    q     = q_sel & mask;
  end
endmodule

// File: rtl/agu_modrev.sv
module agu_modrev #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          upd,
  input  logic [AW-1:0] ptr_in,
  input  logic [AW-1:0] step,
  input  logic          dec,
  input  logic          word,
  input  logic [1:0]    amode,
  input  logic [AW-1:0] buf_lo,
  input  logic [AW-1:0] buf_hi,
  input  logic [AW-1:0] rev_mod,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] ptr_q, nxt_q, ptr_d, calc_now, calc_after, load_val;

  assign load_val = word ? (ptr_in & ~AW'(1)) : ptr_in;

  agu_nextcalc #(.AW(AW)) u_now (
    .p(ptr_q), .step(step), .lo(buf_lo), .hi(buf_hi), .rmod(rev_mod),
    .dec(dec), .word(word), .amode(amode), .q(calc_now)
  );

  always_comb begin
    if (load)     ptr_d = load_val;
    else if (upd) ptr_d = calc_now;
    else          ptr_d = ptr_q;
  end

  agu_nextcalc #(.AW(AW)) u_after (
    .p(ptr_d), .step(step), .lo(buf_lo), .hi(buf_hi), .rmod(rev_mod),
    .dec(dec), .word(word), .amode(amode), .q(calc_after)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      nxt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      nxt_q <= calc_after;
    end
  end

  assign addr = ptr_q;
  assign nxt  = nxt_q;
endmodule

// File: rtl/agu_modrev_chk.sv
module agu_modrev_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic          upd,
  input logic [AW-1:0] ptr_in,
  input logic [AW-1:0] step,
  input logic          dec,
  input logic          word,
  input logic [1:0]    amode,
  input logic [AW-1:0] buf_lo,
  input logic [AW-1:0] buf_hi,
  input logic [AW-1:0] rev_mod,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] nxt
);
  logic in_buf;
  assign in_buf = (addr >= buf_lo) && (addr <= buf_hi);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> addr == ($past(word) ? ($past(ptr_in) & ~AW'(1)) : $past(ptr_in)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !upd) |=> $stable(addr));

  // R10
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    (word && (load || upd)) |=> !addr[0]);

  // R11
  next_match_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && !load && !$past(rst) && $stable(step) && $stable(dec) && $stable(word)
     && $stable(amode) && $stable(buf_lo) && $stable(buf_hi) && $stable(rev_mod))
    |=> addr == $past(nxt));

  // R5
  stay_in_buf_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && !load && amode == 2'b01 && !word && in_buf && (step <= (buf_hi - buf_lo)))
    |=> (addr >= $past(buf_lo)) && (addr <= $past(buf_hi)));
endmodule

bind agu_modrev agu_modrev_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .load(load), .upd(upd), .ptr_in(ptr_in), .step(step),
  .dec(dec), .word(word), .amode(amode), .buf_lo(buf_lo), .buf_hi(buf_hi),
  .rev_mod(rev_mod), .addr(addr), .nxt(nxt)
);

// File: tb/sim_agu_modrev.sv
`timescale 1ns/1ps
module sim_agu_modrev;
  logic        clk = 0;
  logic        rst = 1;
  logic        load = 0, upd = 0, dec = 0, word = 0;
  logic [15:0] ptr_in = 0, step = 0, buf_lo = 0, buf_hi = 0, rev_mod = 0;
  logic [1:0]  amode = 0;
  logic [15:0] addr, nxt;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  agu_modrev u0 (
    .clk(clk), .rst(rst), .load(load), .upd(upd), .ptr_in(ptr_in), .step(step),
    .dec(dec), .word(word), .amode(amode), .buf_lo(buf_lo), .buf_hi(buf_hi),
    .rev_mod(rev_mod), .addr(addr), .nxt(nxt)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bitrev(int v, int n);
    int r = 0;
    for (int i = 0; i < n; i++) if (v & (1 << i)) r |= 1 << (n - 1 - i);
    return r;
  endfunction

  task automatic do_load(logic [15:0] v);
    @(negedge clk); load = 1; ptr_in = v;
    @(negedge clk); load = 0;
  endtask

  // Circular sweep, expected from offset arithmetic.
  task automatic mod_run(string req, int lo, int len, int g, int s, bit d, int n);
    int off = 2 * g;
    int e;
    buf_lo = 16'(lo); buf_hi = 16'(lo + len - g); step = 16'(s); dec = d;
    word = (g == 2); amode = 2'b01;
    do_load(16'(lo + off));
    for (int k = 0; k < n; k++) begin
      upd = 1;
      @(negedge clk);
      off = d ? ((off - s + len) % len) : ((off + s) % len);
      chk(req, addr, 16'(lo + off));
      e = d ? ((off - s + len) % len) : ((off + s) % len);
      chk("R11", nxt, 16'(lo + e));
    end
    upd = 0;
  endtask

  // Bit-reversed sweep: address = base + g * bitrev(k).
  task automatic rev_run(string req, int base, int lg, int g, logic [1:0] md);
    int nn = 1 << lg;
    amode = md; word = (g == 2); rev_mod = 16'(g * nn / 2);
    step = 16'h0006; dec = 1;
    buf_lo = 16'h0000; buf_hi = 16'h0002;
    do_load(16'(base));
    for (int k = 1; k <= 2 * nn; k++) begin
      upd = 1;
      @(negedge clk);
      chk(req, addr, 16'(base + g * bitrev(k % nn, lg)));
      chk("R11", nxt, 16'(base + g * bitrev((k + 1) % nn, lg)));
    end
    upd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", addr, 16'h0000);
    chk("R1", nxt, 16'h0000);
    rst = 0;
    @(negedge clk);
    chk("R1", addr, 16'h0000);

    // R2 load, with byte and word masking (R10)
    word = 0; amode = 2'b00; step = 2; dec = 0;
    do_load(16'h1235);
    chk("R2", addr, 16'h1235);
    word = 1;
    do_load(16'h4321);
    chk("R10", addr, 16'h4320);
    // R2 load wins over upd
    @(negedge clk); load = 1; upd = 1; ptr_in = 16'h0A00;
    @(negedge clk); load = 0; upd = 0;
    chk("R2", addr, 16'h0A00);
    // R3 hold
    repeat (5) @(negedge clk);
    chk("R3", addr, 16'h0A00);

    // R4 linear through 64K boundary both ways
    word = 1; step = 4; dec = 0;
    do_load(16'hFFF8);
    for (int k = 1; k <= 6; k++) begin
      upd = 1; @(negedge clk);
      chk("R4", addr, 16'(16'hFFF8 + 4 * k));
    end
    upd = 0;
    dec = 1; step = 6;
    do_load(16'h0004);
    for (int k = 1; k <= 4; k++) begin
      upd = 1; @(negedge clk);
      chk("R4", addr, 16'(16'h0004 - 6 * k));
    end
    upd = 0;
    // R10 odd step in word mode
    dec = 0; step = 3;
    do_load(16'h0010);
    upd = 1; @(negedge clk); upd = 0;
    chk("R10", addr, 16'h0012);

    // R5/R6 word buffer of 16 words, every step
    for (int s = 2; s <= 32; s += 2) begin
      mod_run("R5", 16'h1000, 32, 2, s, 0, 20);
      mod_run("R6", 16'h1000, 32, 2, s, 1, 20);
    end
    // R5/R6 byte buffer of odd length 7
    for (int s = 1; s <= 7; s++) begin
      mod_run("R5", 16'h2003, 7, 1, s, 0, 15);
      mod_run("R6", 16'h2003, 7, 1, s, 1, 15);
    end

    // R7 pointer below buffer ignores wrap
    word = 1; amode = 2'b01; buf_lo = 16'h1000; buf_hi = 16'h101E;
    step = 8; dec = 0;
    do_load(16'h0F00);
    upd = 1; @(negedge clk); upd = 0;
    chk("R7", addr, 16'h0F08);
    // R7 pointer above buffer decrementing stays linear
    dec = 1;
    do_load(16'h1100);
    upd = 1; @(negedge clk); upd = 0;
    chk("R7", addr, 16'h10F8);

    // R8 bit-reversed, several sizes, word and byte
    rev_run("R8", 16'h0800, 3, 2, 2'b10);
    rev_run("R8", 16'h0800, 4, 2, 2'b10);
    rev_run("R8", 16'h0C00, 5, 2, 2'b10);
    rev_run("R8", 16'h0300, 4, 1, 2'b10);
    // R9 both modes enabled -> bit-reversed
    rev_run("R9", 16'h0800, 4, 2, 2'b11);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule